// File: doc/BRIEF.md
# Debug Register Scan-Chain Access Unit

This unit is the data register that a debugger reaches through a TAP controller to read and write a small bank of on-chip debug registers. Those registers are debug control, debug status, vector catch, and two watchpoint units. Each watchpoint unit holds a value and a mask for address, data and control. The TAP controller supplies the Capture-DR, Shift-DR and Update-DR strobes, qualified to this chain, together with TCK and TDI. The unit returns TDO.

Each scan moves one 38-bit word through the chain. A write scan takes effect at Update-DR: the unit gives the register bank a single-cycle write strobe with the address and the data trimmed to the target register's width.

A read needs two scans:

- The first read scan only records the address at Update-DR.
- The next Capture-DR strobes the bank and loads that register's value, zero-extended, into the data field.
- That value then leaves on TDO during the following shift.

Because the address stays selected, every further scan fetches the same register again. A debugger that reads a register with read side effects must aim its final read scan at a harmless register.

Top module: `dbg_scan_access`

## Requirements
- R1: The chain is 38 bits wide. Bits 31:0 hold data, bits 36:32 hold the register address, and bit 37 is the direction flag. During Shift-DR, TDI enters at bit 37, the word moves toward bit 0 (least-significant bit leaves first), and `tdo` shows bit 0. Outside Shift-DR, `tdo` is 0.
- R2: At Update-DR with direction 1 and an implemented address, `bankWrStb` is high for exactly the following cycle. During that cycle `bankAddr` and `bankWrData` carry the scanned address and data.
- R3: At Update-DR with direction 0, no strobe is issued and the address is recorded. At the next Capture-DR, `bankRdStb` is high in that cycle and the register's value enters bits 31:0, to be shifted out during that scan.
- R4: Write data is truncated to the register's width. The register map, given as address: width, is: 0: 6 (control), 1: 10 (status), 2: 8 (vector catch), 8–11 and 16–19: 32 (watchpoint address/data value and mask), 12 and 20: 9 (watchpoint control value), 13 and 21: 8 (watchpoint control mask).
- R5: Read data is zero-extended: bits of `bankRdData` above the register's width appear as 0 on the chain.
- R6: Addresses outside the map never raise `bankWrStb` or `bankRdStb`, and read back as zero.
- R7: While a read address stays recorded, every Capture-DR strobes that register again. Recording a different address stops further strobes of the first register.
- R8: A write scan cancels any recorded read. The next Capture-DR raises no `bankRdStb` and loads zero data.
- R9: While `trstN` is low and after its release, `tdo`, `bankWrStb`, `bankRdStb`, `bankAddr` and `bankWrData` are 0 and no read is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| captureDr | input | 1 | TAP is in Capture-DR for this chain |
| shiftDr | input | 1 | TAP is in Shift-DR for this chain |
| updateDr | input | 1 | TAP is in Update-DR for this chain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bankAddr | output | 5 | Register address toward the bank |
| bankWrData | output | 32 | Width-trimmed write data |
| bankWrStb | output | 1 | Single-cycle write strobe |
| bankRdStb | output | 1 | Read strobe, high in the Capture-DR cycle |
| bankRdData | input | 32 | Read data from the bank, combinational on bankAddr |

## Verification
Every register in the bench bank starts at all ones. A value that comes back shows whether the upper bits were zeroed; a value written shows whether it was trimmed.

The scan sequences are chosen so that each tells one behaviour apart:

- Write, then read, proves that bits travel least-significant first.
- A run of reads at the same address, then a switch to another address, separates the re-strobe behaviour from a single fetch.
- Unimplemented addresses, in both directions, confirm that no strobe leaves the unit.
- A write placed between a read select and the next capture shows that the pending fetch is dropped.

Strobe timing is compared against a behavioural model on every clock.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int CTRL_W  = 6;
  localparam int STAT_W  = 10;
  localparam int VCAT_W  = 8;
  localparam int WPC_W   = 9;
  localparam int WPCM_W  = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic capLoad;   // Capture-DR: reload chain
    logic rdFetch;   // capture carries bank data
    logic shiftEn;   // Shift-DR
    logic updRead;   // Update-DR, direction 0
    logic updWrite;  // Update-DR, direction 1
  } dpCtl_t;

  // Width of a register; 0 marks an unimplemented address
  function automatic int regWidth(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0:                        return CTRL_W;
      5'd1:                        return STAT_W;
      5'd2:                        return VCAT_W;
      5'd8, 5'd9, 5'd10, 5'd11,
      5'd16, 5'd17, 5'd18, 5'd19:  return DATA_W;
      5'd12, 5'd20:                return WPC_W;
      5'd13, 5'd21:                return WPCM_W;
      default:                     return 0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input logic [ADDR_W-1:0] a);
    int w = regWidth(a);
    logic [DATA_W-1:0] one = DATA_W'(1);
    if (w >= DATA_W) return '1;
    return (one << w) - one;
  endfunction
endpackage

// File: rtl/dbg_scan_ctrl.sv
module dbg_scan_ctrl
  import dbg_scan_pkg::*;
(
  input  logic              tck,
  input  logic              trstN,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              dirBit,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic [ADDR_W-1:0] curAddr,
  output dpCtl_t            ctl,
  output logic              bankRdStb,
  output logic              bankWrStb
);
  logic rdPendQ;
  logic wrStbQ;
  logic curImpl;
  logic selImpl;

  assign curImpl = (regWidth(curAddr) != 0);
  assign selImpl = (regWidth(selAddr) != 0);

  always_comb begin
    ctl.capLoad  = captureDr;
    ctl.rdFetch  = captureDr & rdPendQ & curImpl;
    ctl.shiftEn  = shiftDr;
    ctl.updRead  = updateDr & ~dirBit;
    ctl.updWrite = updateDr & dirBit;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      rdPendQ <= 1'b0;
      wrStbQ  <= 1'b0;
    end else begin
      if (ctl.updRead)       rdPendQ <= 1'b1;
      else if (ctl.updWrite) rdPendQ <= 1'b0;
      wrStbQ <= ctl.updWrite & selImpl;
    end
  end

  assign bankRdStb = ctl.rdFetch;
  assign bankWrStb = wrStbQ;
endmodule

// File: rtl/dbg_scan_dp.sv
module dbg_scan_dp
  import dbg_scan_pkg::*;
(
  input  logic              tck,
  input  logic              trstN,
  input  dpCtl_t            ctl,
  input  logic              tdi,
  input  logic [DATA_W-1:0] bankRdData,
  output logic              tdo,
  output logic              dirBit,
  output logic [ADDR_W-1:0] selAddr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] wrData
);
  logic [CHAIN_W-1:0] shiftQ;
  logic [ADDR_W-1:0]  busAddrQ;
  logic [DATA_W-1:0]  wrDataQ;
  logic [DATA_W-1:0]  capData;

  assign capData = ctl.rdFetch ? (bankRdData & regMask(busAddrQ)) : '0;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftQ   <= '0;
      busAddrQ <= '0;
      wrDataQ  <= '0;
    end else begin
      if (ctl.capLoad)
        shiftQ <= {1'b0, busAddrQ, capData};
      else if (ctl.shiftEn)
        shiftQ <= {tdi, shiftQ[CHAIN_W-1:1]};
      if (ctl.updRead || ctl.updWrite)
        busAddrQ <= shiftQ[DATA_W +: ADDR_W];
      if (ctl.updWrite)
        wrDataQ <= shiftQ[DATA_W-1:0] & regMask(shiftQ[DATA_W +: ADDR_W]);
    end
  end

  assign tdo     = ctl.shiftEn ? shiftQ[0] : 1'b0;
  assign dirBit  = shiftQ[CHAIN_W-1];
  assign selAddr = shiftQ[DATA_W +: ADDR_W];
  assign busAddr = busAddrQ;
  assign wrData  = wrDataQ;
endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
  import dbg_scan_pkg::*;
(
  input  logic              tck,
  input  logic              trstN,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] bankAddr,
  output logic [DATA_W-1:0] bankWrData,
  output logic              bankWrStb,
  output logic              bankRdStb,
  input  logic [DATA_W-1:0] bankRdData
);
  dpCtl_t            ctl;
  logic              dirBit;
  logic [ADDR_W-1:0] selAddr;

  dbg_scan_ctrl ctrl_i (
    .tck(tck), .trstN(trstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .dirBit(dirBit), .selAddr(selAddr),
    .curAddr(bankAddr), .ctl(ctl), .bankRdStb(bankRdStb),
    .bankWrStb(bankWrStb)
  );

  dbg_scan_dp dp_i (
    .tck(tck), .trstN(trstN), .ctl(ctl), .tdi(tdi),
    .bankRdData(bankRdData), .tdo(tdo), .dirBit(dirBit),
    .selAddr(selAddr), .busAddr(bankAddr), .wrData(bankWrData)
  );
endmodule

// File: rtl/dbg_scan_access_chk.sv
module dbg_scan_access_chk
  import dbg_scan_pkg::*;
(
  input logic              tck,
  input logic              trstN,
  input logic              captureDr,
  input logic              shiftDr,
  input logic              updateDr,
  input logic              tdo,
  input logic [ADDR_W-1:0] bankAddr,
  input logic              bankWrStb,
  input logic              bankRdStb
);
  // R1
  tdo_idle_chk: assert property (@(posedge tck) disable iff (!trstN)
    !shiftDr |-> !tdo);

  // R2
  wr_pulse_chk: assert property (@(posedge tck) disable iff (!trstN)
    bankWrStb |=> !bankWrStb);

  // R2
  wr_after_update_chk: assert property (@(posedge tck) disable iff (!trstN)
    bankWrStb |-> $past(updateDr));

  // R3
  rd_in_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    bankRdStb |-> captureDr);

  // R6
  wr_mapped_chk: assert property (@(posedge tck) disable iff (!trstN)
    bankWrStb |-> (regWidth(bankAddr) != 0));

  // R6
  rd_mapped_chk: assert property (@(posedge tck) disable iff (!trstN)
    bankRdStb |-> (regWidth(bankAddr) != 0));
endmodule

bind dbg_scan_access dbg_scan_access_chk chk_i (
  .tck(tck), .trstN(trstN), .captureDr(captureDr), .shiftDr(shiftDr),
  .updateDr(updateDr), .tdo(tdo), .bankAddr(bankAddr),
  .bankWrStb(bankWrStb), .bankRdStb(bankRdStb)
);

// File: tb/dbg_scan_access_tb_top.sv
`timescale 1ns/1ps
module dbg_scan_access_tb_top;
  logic        tck = 1'b0;
  logic        trstN = 1'b0;
  logic        captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [4:0]  bankAddr;
  logic [31:0] bankWrData, bankRdData;
  logic        bankWrStb, bankRdStb;

  logic [31:0] mem [32];
  int          rdCount [32];
  int          checks = 0, errors = 0;

  // Model state
  logic        mPend = 1'b0;
  logic [4:0]  mAddr = '0;
  logic        expRd = 1'b0, expWr = 1'b0;
  logic [4:0]  expWrAddr = '0;
  logic [31:0] expWrData = '0;

  always #4 tck = ~tck;

  dbg_scan_access dut_i (
    .tck(tck), .trstN(trstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .bankAddr(bankAddr),
    .bankWrData(bankWrData), .bankWrStb(bankWrStb), .bankRdStb(bankRdStb),
    .bankRdData(bankRdData)
  );

  // Bench register bank: all ones at start, counts reads
  assign bankRdData = mem[bankAddr];
  always @(posedge tck) begin
    if (bankWrStb) mem[bankAddr] <= bankWrData;
    if (bankRdStb) rdCount[bankAddr] <= rdCount[bankAddr] + 1;
  end

  function automatic int widthOf(input logic [4:0] a);
    if (a == 0) return 6;
    if (a == 1) return 10;
    if (a == 2) return 8;
    if ((a >= 8 && a <= 11) || (a >= 16 && a <= 19)) return 32;
    if (a == 12 || a == 20) return 9;
    if (a == 13 || a == 21) return 8;
    return 0;
  endfunction

  function automatic logic [31:0] trimTo(input logic [4:0] a, input logic [31:0] d);
    int w = widthOf(a);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = d[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge tck) begin
    if (trstN) begin
      check("R3/R6/R7/R8 rdStb", {31'b0, bankRdStb}, {31'b0, expRd});
      check("R2/R6 wrStb", {31'b0, bankWrStb}, {31'b0, expWr});
      if (expWr) begin
        check("R2 wr addr", {27'b0, bankAddr}, {27'b0, expWrAddr});
        check("R4 wr data", bankWrData, expWrData);
      end
    end
  end

  task automatic scan(input logic dir, input logic [4:0] addr,
                      input logic [31:0] data, output logic [31:0] got);
    logic [37:0] vec;
    logic [37:0] outv;
    vec = {dir, addr, data};
    @(posedge tck); #1;
    captureDr = 1'b1;
    expRd = mPend && (widthOf(mAddr) != 0);
    @(posedge tck); #1;
    captureDr = 1'b0;
    expRd = 1'b0;
    shiftDr = 1'b1;
    for (int i = 0; i < 38; i++) begin
      tdi = vec[i];
      #1 outv[i] = tdo;
      @(posedge tck); #1;
    end
    shiftDr = 1'b0;
    updateDr = 1'b1;
    @(posedge tck); #1;
    updateDr = 1'b0;
    if (dir) begin
      mPend = 1'b0;
      expWr = (widthOf(addr) != 0);
      expWrAddr = addr;
      expWrData = trimTo(addr, data);
    end else begin
      mPend = 1'b1;
      mAddr = addr;
    end
    @(posedge tck); #1;
    expWr = 1'b0;
    got = outv[31:0];
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int c1;
    int c0;
    for (int i = 0; i < 32; i++) begin
      mem[i] = 32'hFFFF_FFFF;
      rdCount[i] = 0;
    end
    repeat (3) @(posedge tck);
    #2;
    // R9: reset values
    check("R9 tdo", {31'b0, tdo}, 32'h0);
    check("R9 wrStb", {31'b0, bankWrStb}, 32'h0);
    check("R9 rdStb", {31'b0, bankRdStb}, 32'h0);
    check("R9 addr", {27'b0, bankAddr}, 32'h0);
    check("R9 wrData", bankWrData, 32'h0);
    trstN = 1'b1;
    repeat (2) @(posedge tck);

    scan(1'b1, 5'd8, 32'hA5A5_5A5A, got);            // R2
    check("R2 bank value", mem[8], 32'hA5A5_5A5A);
    scan(1'b1, 5'd0, 32'hFFFF_FFFF, got);            // R4
    check("R4 truncated", mem[0], 32'h0000_003F);
    scan(1'b0, 5'd8, 32'h0, got);                    // R8: nothing pending
    check("R8 no pending data", got, 32'h0);
    scan(1'b0, 5'd1, 32'h0, got);                    // R3, R1
    check("R3 R1 read value", got, 32'hA5A5_5A5A);
    scan(1'b0, 5'd1, 32'h0, got);                    // R5
    check("R5 status zero-ext", got, 32'h0000_03FF);
    check("R7 first fetch", rdCount[1], 1);
    scan(1'b0, 5'd0, 32'h0, got);                    // R7 repeat
    check("R7 repeat data", got, 32'h0000_03FF);
    check("R7 repeat count", rdCount[1], 2);
    scan(1'b0, 5'd3, 32'h0, got);
    check("R5 ctrl read", got, 32'h0000_003F);
    check("R7 stopped", rdCount[1], 2);
    scan(1'b0, 5'd0, 32'h0, got);                    // R6 read
    check("R6 unmapped reads zero", got, 32'h0);
    check("R6 unmapped no strobe", rdCount[3], 0);
    scan(1'b1, 5'd30, 32'h1234_5678, got);           // R6 write
    check("R6 unmapped write ignored", mem[30], 32'hFFFF_FFFF);
    c0 = rdCount[0];
    scan(1'b0, 5'd12, 32'h0, got);                   // R8
    check("R8 cancelled data", got, 32'h0);
    check("R8 cancelled strobe", rdCount[0], c0);
    c1 = rdCount[12];
    scan(1'b1, 5'd12, 32'hFFFF_FFFF, got);
    check("R5 wp ctrl zero-ext", got, 32'h0000_01FF);
    check("R4 wp ctrl truncated", mem[12], 32'h0000_01FF);
    check("R3 fetch counted", rdCount[12], c1 + 1);
    scan(1'b0, 5'd21, 32'h0, got);
    scan(1'b0, 5'd0, 32'h0, got);
    check("R5 wp1 mask zero-ext", got, 32'h0000_00FF);

    repeat (2) @(posedge tck);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule